// File: doc/BRIEF.md
# Dual-Register NCO Phase Core

This block is the core of a numerically controlled oscillator. A register block supplies two 28-bit frequency words, two 12-bit phase-offset words and a set of control bits. On every enabled clock the core adds one of the two frequency words to a 28-bit phase accumulator. It then adds one of the two phase offsets to the accumulator value and turns the result into a 10-bit sawtooth amplitude code for an external DAC. A single-bit square-wave output follows the accumulator MSB, either directly or divided by two.

The select bits choose whole registered words, so changing one has effect at the next clock edge. A word is never built from parts of two registers. A clear control holds all internal state at zero, which puts the amplitude code at midscale. A sleep control freezes the accumulator and both outputs at their present values.

Top module: `nco_phase_core`

## Requirements
- R1: On each rising clock edge with clr_i=0 and sleep_i=0, the accumulator takes the value (acc + selected frequency word) mod 2^28.
- R2: fsel_i=0 selects freq0_i as the increment and fsel_i=1 selects freq1_i. A change of fsel_i applies the whole new word from the next edge on, with no mixing of bits from the two words.
- R3: psel_i=0 selects phase0_i and psel_i=1 selects phase1_i. The selected 12-bit offset is placed at bits 27:16 and added to the accumulator value. The sum wraps mod 2^28 and is registered as the output phase on each enabled edge.
- R4: dac_o equals bits 27:18 of the registered output phase with bit 9 (the MSB) inverted. A zero phase therefore gives 512.
- R5: While clr_i=1, every edge sets the accumulator, the output phase and the divider state to 0, so dac_o=512 and the undivided square output is 0.
- R6: While sleep_i=1 and clr_i=0, the accumulator, dac_o and sq_o keep their values and do not follow changes on the select or word inputs.
- R7: When sq_en_i=0, sq_o is 0 whatever the accumulator state.
- R8: With sq_en_i=1 and div2_i=0, sq_o equals accumulator bit 27. With div2_i=1, sq_o is a divider flop that toggles on the first enabled edge after accumulator bit 27 goes from 0 to 1.
- R9: An active-low asynchronous rst_ni puts the block in the same state as clr_i=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq0_i | input | 28 | Frequency word 0 |
| freq1_i | input | 28 | Frequency word 1 |
| phase0_i | input | 12 | Phase offset 0 |
| phase1_i | input | 12 | Phase offset 1 |
| fsel_i | input | 1 | Frequency word select |
| psel_i | input | 1 | Phase offset select |
| clr_i | input | 1 | Synchronous clear to midscale |
| sleep_i | input | 1 | Freeze accumulation and outputs |
| sq_en_i | input | 1 | Square output enable |
| div2_i | input | 1 | Square output divided by two |
| dac_o | output | 10 | Sawtooth amplitude code |
| sq_o | output | 1 | Square-wave output |

## Verification
The divided square output is the hardest case to reach from the ports. Its state is a hidden flop that changes only on a 0-to-1 transition of accumulator bit 27. It must also hold through sleep and be cleared by clr_i. The bench uses a frequency word of 2^24, which flips bit 27 every eight edges. It runs several full divided periods, inserts a sleep window that covers a transition, and compares every cycle against a cycle model built from the requirements. Frequency-select switching in the middle of a run is checked the same way, one cycle at a time, to show that no partial words are mixed.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned ACC_W_DEF = 28;
  localparam int unsigned PH_W_DEF  = 12;
  localparam int unsigned DAC_W_DEF = 10;

  typedef struct packed {
    logic fsel;
    logic psel;
    logic clr;
    logic run;
    logic sq_en;
    logic div2;
  } nco_ctrl_t;
endpackage

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int unsigned ACC_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] freq0_i,
  input  logic [ACC_W-1:0] freq1_i,
  input  logic             fsel_i,
  input  logic             clr_i,
  input  logic             run_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] inc;
  logic [ACC_W-1:0] acc_q;
  logic             armed_q;

  assign inc = fsel_i ? freq1_i : freq0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (run_i)  acc_q <= acc_q + inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign acc_o = acc_q;

  AST_ACC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0); // R5
  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !clr_i && run_i) |=>
      acc_o == $past(acc_o) + ($past(fsel_i) ? $past(freq1_i) : $past(freq0_i))); // R1
  AST_ACC_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !clr_i && !run_i) |=> $stable(acc_o)); // R6
endmodule

// File: rtl/nco_phase_add.sv
module nco_phase_add #(
  parameter int unsigned ACC_W = 28,
  parameter int unsigned PH_W  = 12,
  parameter int unsigned DAC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [PH_W-1:0]  phase0_i,
  input  logic [PH_W-1:0]  phase1_i,
  input  logic             psel_i,
  input  logic             clr_i,
  input  logic             run_i,
  output logic [DAC_W-1:0] dac_o
);
  localparam int unsigned PAD_W = ACC_W - PH_W;

  logic [PH_W-1:0]  off;
  logic [ACC_W-1:0] off_al;
  logic [ACC_W-1:0] ph_q;
  logic             armed_q;

  assign off    = psel_i ? phase1_i : phase0_i;
  assign off_al = {off, {PAD_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (clr_i)  ph_q <= '0;
    else if (run_i)  ph_q <= acc_i + off_al;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // sawtooth: offset-binary from top bits
  assign dac_o = {~ph_q[ACC_W-1], ph_q[ACC_W-2 -: DAC_W-1]};

  AST_DAC_MIDSCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> dac_o == DAC_W'(1 << (DAC_W-1))); // R5
  AST_DAC_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !clr_i && !run_i) |=> $stable(dac_o)); // R6
endmodule

// File: rtl/nco_sq_out.sv
module nco_sq_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic msb_i,
  input  logic clr_i,
  input  logic run_i,
  input  logic en_i,
  input  logic div2_i,
  output logic sq_o
);
  logic msb_d_q;
  logic div_q;
  logic rise;
  logic armed_q;

  assign rise = msb_i & ~msb_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_d_q <= 1'b0;
      div_q   <= 1'b0;
    end else if (clr_i) begin
      msb_d_q <= 1'b0;
      div_q   <= 1'b0;
    end else if (run_i) begin
      msb_d_q <= msb_i;
      if (rise) div_q <= ~div_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign sq_o = en_i & (div2_i ? div_q : msb_i);

  AST_DIV_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !clr_i && run_i && msb_i && !msb_d_q) |=> div_q != $past(div_q)); // R8
  AST_DIV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !clr_i && !(run_i && msb_i && !msb_d_q)) |=> $stable(div_q)); // R8
  AST_DIV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !div_q); // R5
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int unsigned ACC_W = ACC_W_DEF,
  parameter int unsigned PH_W  = PH_W_DEF,
  parameter int unsigned DAC_W = DAC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] freq0_i,
  input  logic [ACC_W-1:0] freq1_i,
  input  logic [PH_W-1:0]  phase0_i,
  input  logic [PH_W-1:0]  phase1_i,
  input  logic             fsel_i,
  input  logic             psel_i,
  input  logic             clr_i,
  input  logic             sleep_i,
  input  logic             sq_en_i,
  input  logic             div2_i,
  output logic [DAC_W-1:0] dac_o,
  output logic             sq_o
);
  nco_ctrl_t        ctrl;
  logic [ACC_W-1:0] acc;

  assign ctrl = '{fsel: fsel_i, psel: psel_i, clr: clr_i, run: ~sleep_i,
                  sq_en: sq_en_i, div2: div2_i};

  nco_accum #(.ACC_W(ACC_W)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .freq0_i (freq0_i),
    .freq1_i (freq1_i),
    .fsel_i  (ctrl.fsel),
    .clr_i   (ctrl.clr),
    .run_i   (ctrl.run),
    .acc_o   (acc)
  );

  nco_phase_add #(.ACC_W(ACC_W), .PH_W(PH_W), .DAC_W(DAC_W)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (acc),
    .phase0_i (phase0_i),
    .phase1_i (phase1_i),
    .psel_i   (ctrl.psel),
    .clr_i    (ctrl.clr),
    .run_i    (ctrl.run),
    .dac_o    (dac_o)
  );

  nco_sq_out u_sq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .msb_i  (acc[ACC_W-1]),
    .clr_i  (ctrl.clr),
    .run_i  (ctrl.run),
    .en_i   (ctrl.sq_en),
    .div2_i (ctrl.div2),
    .sq_o   (sq_o)
  );

  AST_SQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sq_en_i |-> !sq_o); // R7
endmodule

// File: tb/tb_nco_phase_core.sv
module tb_nco_phase_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] freq0 = '0, freq1 = '0;
  logic [11:0] phase0 = '0, phase1 = '0;
  logic        fsel = 0, psel = 0, clr = 0, sleep = 0, sq_en = 1, div2 = 0;
  logic [9:0]  dac;
  logic        sq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [27:0] m_acc, m_ph;
  logic        m_msbd, m_div;

  always #10 clk = ~clk;

  nco_phase_core dut (
    .clk_i(clk), .rst_ni(rst_n), .freq0_i(freq0), .freq1_i(freq1),
    .phase0_i(phase0), .phase1_i(phase1), .fsel_i(fsel), .psel_i(psel),
    .clr_i(clr), .sleep_i(sleep), .sq_en_i(sq_en), .div2_i(div2),
    .dac_o(dac), .sq_o(sq)
  );

  // stimulus: freq0, freq1, phase0, phase1, fsel, psel, cycles
  localparam int NV = 6;
  localparam logic [88:0] VEC [NV] = '{
    {28'h0001000, 28'h0000000, 12'h000, 12'h000, 1'b0, 1'b0, 7'd40},
    {28'h0000000, 28'h0123457, 12'h000, 12'h000, 1'b1, 1'b0, 7'd50},
    {28'h0400000, 28'h0000001, 12'h800, 12'h000, 1'b0, 1'b0, 7'd30},
    {28'h0000000, 28'h3000000, 12'h000, 12'hC40, 1'b1, 1'b1, 7'd25},
    {28'hFFFFFFF, 28'h0000000, 12'h001, 12'h7FF, 1'b0, 1'b1, 7'd20},
    {28'h8000001, 28'h5555555, 12'hFFF, 12'h123, 1'b1, 1'b0, 7'd30}
  };

  function automatic logic [9:0] amp(input logic [27:0] p);
    return {~p[27], p[26:18]};
  endfunction

  function automatic logic exp_sq();
    if (!sq_en) return 1'b0;
    return div2 ? m_div : m_acc[27];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_acc = '0; m_ph = '0; m_msbd = 0; m_div = 0;
  endtask

  // one clock: model updates from inputs held since last negedge
  task automatic step();
    @(posedge clk);
    if (clr) model_reset();
    else if (!sleep) begin
      m_ph = m_acc + {(psel ? phase1 : phase0), 16'h0};
      if (m_acc[27] && !m_msbd) m_div = ~m_div;
      m_msbd = m_acc[27];
      m_acc = m_acc + (fsel ? freq1 : freq0);
    end
    @(negedge clk);
  endtask

  task automatic check_out(input string req);
    chk(req, 32'(dac), 32'(amp(m_ph)));
    chk(req, 32'(sq), 32'(exp_sq()));
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [9:0] hold_dac;
    logic       hold_sq;
    model_reset();
    repeat (3) @(negedge clk);
    // R9: async reset state
    chk("R9 reset dac", 32'(dac), 32'd512);
    chk("R9 reset sq", 32'(sq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 table walk
    for (int v = 0; v < NV; v++) begin
      clr = 1; step();
      check_out("R5 clear midscale");
      clr = 0;
      {freq0, freq1, phase0, phase1, fsel, psel} = VEC[v][88:7];
      for (int c = 0; c < int'(VEC[v][6:0]); c++) begin
        step();
        check_out("R1 R2 R3 R4 vector");
      end
    end

    // R2: switch frequency select mid-run, per-cycle compare
    freq0 = 28'h0ABCDEF; freq1 = 28'h7F00003; phase0 = 12'h010; psel = 0; fsel = 0;
    for (int c = 0; c < 24; c++) begin
      if (c % 5 == 2) fsel = ~fsel;
      step();
      check_out("R2 select switch");
    end

    // R3: phase select switch, wrap of the sum
    freq0 = 28'hF000000; phase0 = 12'hFFF; phase1 = 12'h001; fsel = 0;
    for (int c = 0; c < 10; c++) begin
      psel = c[0];
      step();
      check_out("R3 phase select wrap");
    end

    // R8: undivided and divided square output
    clr = 1; step(); clr = 0;
    freq0 = 28'h1000000; fsel = 0; div2 = 0; sq_en = 1;
    for (int c = 0; c < 20; c++) begin step(); check_out("R8 undivided"); end
    div2 = 1;
    for (int c = 0; c < 70; c++) begin step(); check_out("R8 divided"); end

    // R6: sleep freezes outputs while inputs change
    hold_dac = dac; hold_sq = sq;
    sleep = 1;
    for (int c = 0; c < 12; c++) begin
      fsel = c[0]; psel = c[1]; freq1 = 28'h0FFFFFF; phase1 = 12'h5A5;
      step();
      chk("R6 sleep dac", 32'(dac), 32'(hold_dac));
      chk("R6 sleep sq", 32'(sq), 32'(hold_sq));
    end
    sleep = 0; fsel = 0; psel = 0;
    for (int c = 0; c < 20; c++) begin step(); check_out("R6 resume"); end

    // R7: disabled square output
    sq_en = 0;
    for (int c = 0; c < 20; c++) begin step(); chk("R7 sq disabled", 32'(sq), 32'd0); end
    sq_en = 1; div2 = 0;

    // R5: clear held for several cycles
    clr = 1;
    for (int c = 0; c < 3; c++) begin
      step();
      chk("R5 clear dac", 32'(dac), 32'd512);
      chk("R5 clear sq", 32'(sq), 32'd0);
    end
    clr = 0;
    for (int c = 0; c < 5; c++) begin step(); check_out("R5 after clear"); end

    // R9: async reset mid-run, between edges
    #3 rst_n = 0;
    #2;
    model_reset();
    chk("R9 async dac", 32'(dac), 32'd512);
    chk("R9 async sq", 32'(sq), 32'd0);
    @(negedge clk); rst_n = 1;
    for (int c = 0; c < 5; c++) begin step(); check_out("R9 after reset"); end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule